// File: doc/BRIEF.md
# Guarded byte-wide nonvolatile data store controller

This block places a small byte-wide data store behind a four-register CPU bus. The CPU picks a register with a 2-bit select and either writes it (bus_we high for one cycle) or reads it combinationally on `bus_rdata`. The select codes are 0 for the address register, 1 for the data register, 2 for the control register and 3 for the key register. A read takes one cycle: the CPU sets the read strobe, and the addressed byte sits in the data register on the next cycle. The store itself is modelled as an internal RAM. A write to it takes a fixed number of cycles, set by a parameter.

A write cannot start from a plain strobe. The write-enable bit must already be set. Then the key register must receive 0x55 and 0xAA on two back-to-back bus cycles, and the control register write that sets the write strobe must come on the very next cycle. The key sequence lives in its own state machine. UL_IDLE moves to UL_HAVE_FIRST on 0x55, and UL_HAVE_FIRST moves to UL_ARMED on 0xAA in the next cycle. Any other activity sends it back to UL_IDLE, and UL_ARMED always falls back to UL_IDLE after one cycle. A second state machine times the write. It moves from WT_IDLE to WT_BUSY on an accepted start and returns to WT_IDLE once the latency has run out. On that return the byte is committed and a sticky completion flag (also driven on `irq_o`) is raised.

After power-on, a lockout counter of PUT_CYCLES cycles blocks every write start. The power-on input `por_n` is asynchronous and clears everything. The warm reset `rst_n` is synchronous. It clears the registers and the state machines but keeps an error flag, and that flag is set when the warm reset cuts a write short.

Top module: `nvm_guard`

## Requirements
- R1: Writing the control register (select 2) with bit 0 set while no write is in progress loads the data register with the byte at the address register. The byte reads back on select 1 in the very next cycle. Bit 0 always reads back as 0.
- R2: The data register keeps its value across idle cycles. It changes only on a read (R1) or a CPU write to select 1.
- R3: A write starts only on this sequence of three consecutive bus write cycles: select 3 with 0x55, then select 3 with 0xAA, then select 2 with bit 1 set. While the write runs, control bits 1 and 5 both read 1.
- R4: An idle cycle, a wrong value or any other bus write inside the sequence aborts it, and no write starts. Keys in the wrong order also start nothing. Select 3 always reads 0.
- R5: A start is accepted only if control bit 2 (write-enable) was already 1 before the strobe write. Only a CPU write to bit 2 or a reset changes that bit.
- R6: When the write ends, bits 1 and 5 clear and bit 4 (completion) sets, and `irq_o` follows bit 4. Clearing write-enable during the write does not cancel it. Bit 4 clears only when the CPU writes 0 to it.
- R7: No write starts during the first PUT_CYCLES cycles after `por_n` is released.
- R8: A write stays in progress for exactly WR_CYCLES cycles and then commits the data register byte at the address register. A later read returns that byte.
- R9: While a write is in progress, the block ignores read strobes and CPU writes to select 0 and select 1.
- R10: A low `rst_n` cycle clears the address, data, write-enable and completion bits. If a write was in progress, it is dropped without a commit and control bit 3 (error) is set. Bit 3 survives `rst_n` and clears when the CPU writes 0 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; restarts the lockout |
| rst_n | input | 1 | Synchronous warm reset, active low |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the selected register |
| irq_o | output | 1 | Sticky write-completion flag |

## Verification
If the key machine is stuck in UL_ARMED or skips UL_HAVE_FIRST, a broken sequence still starts a write. That shows up at the ports one cycle later, as control bit 5 set when it should be clear. If the latency counter is off by one, bit 5 drops one cycle early or late. So the bench reads the control register on the last busy cycle and again on the first cycle after the write. A write that commits the wrong byte or address, or one that a warm reset fails to drop, shows up only on a later read. The bench therefore reads every written address back after the write and after the reset.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam int DW = 8;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_KEY  = 2'd3;

    localparam int B_RD   = 0;
    localparam int B_WR   = 1;
    localparam int B_WEN  = 2;
    localparam int B_ERR  = 3;
    localparam int B_DONE = 4;
    localparam int B_BUSY = 5;

    localparam logic [DW-1:0] KEY_FIRST  = 8'h55;
    localparam logic [DW-1:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_HAVE_FIRST,
        UL_ARMED
    } ul_state_t;

    typedef enum logic {
        WT_IDLE,
        WT_BUSY
    } wt_state_t;
endpackage

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nvm_unlock.sv
module nvm_unlock
    import nvm_pkg::*;
(
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          key_we,
    input  logic [DW-1:0] key_val,
    output logic          armed
);
    ul_state_t state, state_nx;

    always_comb begin
        state_nx = UL_IDLE;
        unique case (state)
            UL_IDLE:       if (key_we && key_val == KEY_FIRST)  state_nx = UL_HAVE_FIRST;
            UL_HAVE_FIRST: if (key_we && key_val == KEY_SECOND) state_nx = UL_ARMED;
            UL_ARMED:      state_nx = UL_IDLE;
            default:       state_nx = UL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= UL_IDLE;
        end else if (!rst_n) begin
            state <= UL_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        armed = (state == UL_ARMED);
    end

    // the armed window lasts exactly one cycle
    assert_arm_one_shot_R4: assert property (@(posedge clk) disable iff (!por_n)
        (state == UL_ARMED) |=> (state == UL_IDLE));
endmodule

// File: rtl/nvm_wtimer.sv
module nvm_wtimer
    import nvm_pkg::*;
#(
    parameter int WR_CYCLES  = 200_000,
    parameter int PUT_CYCLES = 3_600_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic start_req,
    output logic busy,
    output logic started,
    output logic finish,
    output logic abort,
    output logic locked
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    localparam int PW = $clog2(PUT_CYCLES + 1);

    wt_state_t     state, state_nx;
    logic [CW-1:0] cnt;
    logic [PW-1:0] put_cnt;

    assign locked = (put_cnt != PW'(PUT_CYCLES));

    always_comb begin
        state_nx = state;
        unique case (state)
            WT_IDLE: if (started)    state_nx = WT_BUSY;
            WT_BUSY: if (cnt == '0)  state_nx = WT_IDLE;
            default: state_nx = WT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= WT_IDLE;
        end else if (!rst_n) begin
            state <= WT_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (!rst_n) begin
            cnt <= '0;
        end else if (started) begin
            cnt <= CW'(WR_CYCLES - 1);
        end else if (busy && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            put_cnt <= '0;
        end else if (locked) begin
            put_cnt <= put_cnt + 1'b1;
        end
    end

    always_comb begin
        busy    = (state == WT_BUSY);
        started = start_req && !locked && (state == WT_IDLE) && rst_n;
        finish  = busy && (cnt == '0) && rst_n;
        abort   = busy && !rst_n;
    end

    assert_count_down_R8: assert property (@(posedge clk) disable iff (!por_n)
        (busy && $past(busy) && $past(rst_n)) |-> (cnt == $past(cnt) - 1'b1));

    assert_no_busy_in_lockout_R7: assert property (@(posedge clk) disable iff (!por_n)
        locked |-> !busy);
endmodule

// File: rtl/nvm_guard.sv
module nvm_guard
    import nvm_pkg::*;
#(
    parameter int AW         = 6,
    parameter int WR_CYCLES  = 200_000,
    parameter int PUT_CYCLES = 3_600_000
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [1:0]    bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          wen_q;
    logic          err_q;
    logic          done_q;

    logic          wr_addr, wr_data, wr_ctrl, wr_key;
    logic          armed, start_req, rd_go;
    logic          busy, started, finish, abort, locked;
    logic [DW-1:0] arr_rdata;

    assign wr_addr = bus_we && (bus_sel == SEL_ADDR);
    assign wr_data = bus_we && (bus_sel == SEL_DATA);
    assign wr_ctrl = bus_we && (bus_sel == SEL_CTRL);
    assign wr_key  = bus_we && (bus_sel == SEL_KEY);

    assign start_req = armed && wr_ctrl && bus_wdata[B_WR] && wen_q;
    assign rd_go     = wr_ctrl && bus_wdata[B_RD] && !busy && !started;

    nvm_unlock u_unlock (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .key_we  (wr_key),
        .key_val (bus_wdata),
        .armed   (armed)
    );

    nvm_wtimer #(
        .WR_CYCLES  (WR_CYCLES),
        .PUT_CYCLES (PUT_CYCLES)
    ) u_wtimer (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .start_req (start_req),
        .busy      (busy),
        .started   (started),
        .finish    (finish),
        .abort     (abort),
        .locked    (locked)
    );

    nvm_array #(
        .AW (AW),
        .DW (DW)
    ) u_array (
        .clk   (clk),
        .we    (finish),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr_q),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            addr_q <= '0;
            data_q <= '0;
            wen_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            wen_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (wr_addr && !busy) begin
                addr_q <= bus_wdata[AW-1:0];
            end
            if (rd_go) begin
                data_q <= arr_rdata;
            end else if (wr_data && !busy) begin
                data_q <= bus_wdata;
            end
            if (wr_ctrl) begin
                wen_q <= bus_wdata[B_WEN];
            end
            if (finish) begin
                done_q <= 1'b1;
            end else if (wr_ctrl && !bus_wdata[B_DONE]) begin
                done_q <= 1'b0;
            end
        end
    end

    // error flag: only power-on clears it in hardware
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            err_q <= 1'b0;
        end else if (abort) begin
            err_q <= 1'b1;
        end else if (rst_n && wr_ctrl && !bus_wdata[B_ERR]) begin
            err_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_sel)
            SEL_ADDR: bus_rdata = DW'(addr_q);
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: bus_rdata = {2'b00, busy, done_q, err_q, wen_q, busy, 1'b0};
            SEL_KEY:  bus_rdata = '0;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = done_q;

    assert_wen_gate_R5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(busy) |-> $past(wen_q));

    assert_lockout_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(busy) |-> !$past(locked));

    assert_done_on_end_R6: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(busy) && $past(rst_n)) |-> done_q);

    assert_regs_frozen_R9: assert property (@(posedge clk) disable iff (!por_n)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q)));

    assert_abort_flags_R10: assert property (@(posedge clk) disable iff (!por_n)
        ($past(busy) && !$past(rst_n)) |-> (err_q && !busy));
endmodule

// File: tb/nvm_guard_tb.sv
module nvm_guard_tb;
    localparam int AW  = 4;
    localparam int WRC = 4;
    localparam int PUT = 30;

    localparam logic [1:0] K_I = 2'd0;
    localparam logic [1:0] K_W = 2'd1;
    localparam logic [1:0] K_C = 2'd2;
    localparam logic [1:0] K_Q = 2'd3;

    localparam logic [1:0] S_A = 2'd0;
    localparam logic [1:0] S_D = 2'd1;
    localparam logic [1:0] S_C = 2'd2;
    localparam logic [1:0] S_K = 2'd3;

    typedef struct packed {
        logic [1:0] kind;
        logic [1:0] sel;
        logic [7:0] dat;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 61;
    localparam vec_t VECS [NV] = '{
        // first write: R3, R8, R9
        '{K_W, S_A, 8'h03, 8'h00, 4'd3},
        '{K_W, S_D, 8'hA5, 8'h00, 4'd3},
        '{K_W, S_K, 8'h55, 8'h00, 4'd3},
        '{K_W, S_K, 8'hAA, 8'h00, 4'd3},
        '{K_W, S_C, 8'h06, 8'h00, 4'd3},
        '{K_C, S_C, 8'h00, 8'h26, 4'd3},   // R3 busy
        '{K_W, S_A, 8'h07, 8'h00, 4'd9},   // R9 ignored
        '{K_W, S_C, 8'h07, 8'h00, 4'd9},   // R9 read ignored
        '{K_C, S_C, 8'h00, 8'h26, 4'd8},   // R8 last busy cycle
        '{K_C, S_C, 8'h00, 8'h14, 4'd6},   // R6 done
        '{K_Q, S_C, 8'h00, 8'h01, 4'd6},   // R6 irq pin
        '{K_C, S_A, 8'h00, 8'h03, 4'd9},
        '{K_C, S_D, 8'h00, 8'hA5, 4'd9},
        '{K_W, S_D, 8'h00, 8'h00, 4'd2},
        '{K_C, S_D, 8'h00, 8'h00, 4'd2},   // R2 cpu write
        '{K_W, S_C, 8'h05, 8'h00, 4'd1},
        '{K_C, S_D, 8'h00, 8'hA5, 4'd1},   // R1 next cycle
        '{K_C, S_C, 8'h00, 8'h04, 4'd6},   // R6 done cleared
        '{K_I, S_C, 8'h00, 8'h00, 4'd2},
        '{K_C, S_D, 8'h00, 8'hA5, 4'd2},   // R2 hold
        '{K_C, S_K, 8'h00, 8'h00, 4'd4},   // R4 key reads 0
        // wrong second key: R4
        '{K_W, S_K, 8'h55, 8'h00, 4'd4},
        '{K_W, S_K, 8'hAB, 8'h00, 4'd4},
        '{K_W, S_C, 8'h06, 8'h00, 4'd4},
        '{K_C, S_C, 8'h00, 8'h04, 4'd4},
        // gap between keys: R4
        '{K_W, S_K, 8'h55, 8'h00, 4'd4},
        '{K_I, S_C, 8'h00, 8'h00, 4'd4},
        '{K_W, S_K, 8'hAA, 8'h00, 4'd4},
        '{K_W, S_C, 8'h06, 8'h00, 4'd4},
        '{K_C, S_C, 8'h00, 8'h04, 4'd4},
        // gap before strobe: R4
        '{K_W, S_K, 8'h55, 8'h00, 4'd4},
        '{K_W, S_K, 8'hAA, 8'h00, 4'd4},
        '{K_I, S_C, 8'h00, 8'h00, 4'd4},
        '{K_W, S_C, 8'h06, 8'h00, 4'd4},
        '{K_C, S_C, 8'h00, 8'h04, 4'd4},
        // keys swapped: R4
        '{K_W, S_K, 8'hAA, 8'h00, 4'd4},
        '{K_W, S_K, 8'h55, 8'h00, 4'd4},
        '{K_W, S_C, 8'h06, 8'h00, 4'd4},
        '{K_C, S_C, 8'h00, 8'h04, 4'd4},
        // write-enable off: R5
        '{K_W, S_C, 8'h00, 8'h00, 4'd5},
        '{K_W, S_K, 8'h55, 8'h00, 4'd5},
        '{K_W, S_K, 8'hAA, 8'h00, 4'd5},
        '{K_W, S_C, 8'h02, 8'h00, 4'd5},
        '{K_C, S_C, 8'h00, 8'h00, 4'd5},
        // second write, enable dropped mid-write: R6, R8, R9
        '{K_W, S_C, 8'h04, 8'h00, 4'd6},
        '{K_W, S_A, 8'h09, 8'h00, 4'd6},
        '{K_W, S_D, 8'h77, 8'h00, 4'd6},
        '{K_W, S_K, 8'h55, 8'h00, 4'd6},
        '{K_W, S_K, 8'hAA, 8'h00, 4'd6},
        '{K_W, S_C, 8'h06, 8'h00, 4'd6},
        '{K_W, S_C, 8'h00, 8'h00, 4'd6},
        '{K_W, S_D, 8'h11, 8'h00, 4'd9},
        '{K_I, S_C, 8'h00, 8'h00, 4'd6},
        '{K_I, S_C, 8'h00, 8'h00, 4'd6},
        '{K_C, S_C, 8'h00, 8'h10, 4'd6},   // R6 not cancelled
        '{K_C, S_D, 8'h00, 8'h77, 4'd9},
        '{K_W, S_C, 8'h01, 8'h00, 4'd8},
        '{K_C, S_D, 8'h00, 8'h77, 4'd8},   // R8 committed
        '{K_W, S_A, 8'h03, 8'h00, 4'd8},
        '{K_W, S_C, 8'h01, 8'h00, 4'd8},
        '{K_C, S_D, 8'h00, 8'hA5, 4'd8}
    };

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    nvm_guard #(
        .AW         (AW),
        .WR_CYCLES  (WRC),
        .PUT_CYCLES (PUT)
    ) u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_sel   = s;
        bus_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input logic [1:0] s, input logic [7:0] e, input int r);
        @(negedge clk);
        bus_we  = 1'b0;
        bus_sel = s;
        #1;
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL R%0d sel %0d actual %02h expected %02h", r, s, bus_rdata, e);
        end
    endtask

    task automatic chk_irq(input logic e, input int r);
        @(negedge clk);
        bus_we = 1'b0;
        #1;
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL R%0d irq actual %0b expected %0b", r, irq_o, e);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;

        // reset state: R10, R5
        chk(S_A, 8'h00, 10);
        chk(S_D, 8'h00, 10);
        chk(S_C, 8'h00, 5);
        chk(S_K, 8'h00, 4);
        chk_irq(1'b0, 10);

        // lockout still running: R7
        wr(S_A, 8'h03);
        wr(S_D, 8'h5A);
        wr(S_C, 8'h04);
        wr(S_K, 8'h55);
        wr(S_K, 8'hAA);
        wr(S_C, 8'h06);
        chk(S_C, 8'h04, 7);
        repeat (40) idle();

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].kind)
                K_I: idle();
                K_W: wr(VECS[i].sel, VECS[i].dat);
                K_C: chk(VECS[i].sel, VECS[i].exp, int'(VECS[i].req));
                K_Q: chk_irq(VECS[i].exp[0], int'(VECS[i].req));
                default: idle();
            endcase
        end

        // warm reset in the middle of a write: R10
        wr(S_C, 8'h04);
        wr(S_D, 8'hEE);
        wr(S_K, 8'h55);
        wr(S_K, 8'hAA);
        wr(S_C, 8'h06);
        idle();
        @(negedge clk);
        bus_we = 1'b0;
        rst_n  = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        chk(S_C, 8'h08, 10);
        chk(S_A, 8'h00, 10);
        chk_irq(1'b0, 10);
        wr(S_C, 8'h0C);
        chk(S_C, 8'h0C, 10);
        wr(S_C, 8'h00);
        chk(S_C, 8'h00, 10);
        repeat (6) idle();
        wr(S_A, 8'h03);
        wr(S_C, 8'h01);
        chk(S_D, 8'hA5, 10);

        finish_run();
    end
endmodule